// File: doc/BRIEF.md
# Memory Access Permission Guard

This block decides, for every memory request, whether the access may proceed. It holds sixteen protection entries. Each entry has an 8-bit configuration and an address register. Both are loaded through an indexed write port. A request carries a byte address, an access kind (load, store or fetch) and a flag that marks machine privilege. The guard answers with a single allow bit in the same cycle.

An entry describes its region in one of two ways. In the first, the region runs from the previous entry's bound up to its own bound. In the second, the region is a naturally aligned power-of-two block, with the size encoded in the trailing ones of the address register. The lowest-numbered entry that matches decides the result.

A lock bit freezes an entry until reset. It also makes that entry's permissions bind machine-mode requests, which otherwise pass freely. Software loads and locks the entries during boot. From then on, the core consults the allow bit on every access.

Top module: `mem_guard`

## Requirements
- R1: After reset every entry is disabled: a lower-privilege request is denied and a machine request is allowed.
- R2: The configuration byte holds read permit in bit 0, write permit in bit 1, fetch permit in bit 2, region mode in bits 4:3 and lock in bit 7. Bits 6:5 are reserved and read as zero.
- R3: Region mode 1 selects bounded range and mode 3 selects aligned power-of-two. Modes 0 and 2 make the entry match nothing.
- R4: In bounded-range mode, entry 0 matches word addresses below its register. Entry i matches word addresses at or above the register of entry i-1 and below its own register. The word address is byte address bits 31:2.
- R5: In aligned mode, a register holding k trailing ones followed by a zero covers 2^(k+3) bytes, with a base equal to the register with those k+1 low bits cleared, times 4. The smallest region is 8 bytes.
- R6: When several entries match, the lowest-numbered one alone decides.
- R7: Access kind 0 is a load and checks the read permit. Kind 1 is a store and checks the write permit. Kind 2 is a fetch and checks the fetch permit. Kind 3 is denied wherever permissions apply.
- R8: A lower-privilege request that matches no entry is denied. One that matches is decided by the winning entry's permits.
- R9: A machine request is allowed unless its winning entry is locked. In that case the permits of the winning entry decide.
- R10: While an entry's lock bit is set, writes to its configuration and address register are ignored until reset.
- R11: A write with `wr_is_addr` = 1 loads `wr_data` into the address register of `wr_idx`. With `wr_is_addr` = 0 it loads `wr_data[7:0]` into the configuration. Either takes effect from the next cycle.
- R12: `allow` is a combinational function of the request inputs and the stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_is_addr | input | 1 | 1 selects the address register, 0 the configuration |
| wr_idx | input | 4 | Entry index for the write |
| wr_data | input | 30 | Write data (configuration in bits 7:0) |
| req_addr | input | 32 | Byte address of the request |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| req_mach | input | 1 | 1 for a machine-privilege request |
| allow | output | 1 | 1 when the request may proceed |

## Verification
The assertions assume that the request and write inputs are known, with no X values, at every clock edge after reset. They also assume that `wr_idx` always names an existing entry. The bench drives all inputs to defined values from time zero and changes them only on falling edges. It keeps every index inside 0 to 15. The bench never expects a locked entry to change. The only way to change a locked entry is reset, and the bench asserts reset once at the start.

// File: rtl/mg_pkg.sv
package mg_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_RANGE = 2'd1,
        MODE_SPARE = 2'd2,
        MODE_ALIGN = 2'd3
    } region_mode_e;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_BAD   = 2'd3
    } access_kind_e;

    // Field positions follow the configuration byte layout (R2).
    typedef struct packed {
        logic         lock;
        logic [1:0]   spare;
        region_mode_e mode;
        logic         px;
        logic         pw;
        logic         pr;
    } entry_cfg_t;

endpackage

// File: rtl/mg_regs.sv
module mg_regs
    import mg_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned WORD_W  = 30,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_is_addr,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [WORD_W-1:0]               wr_data,
    output entry_cfg_t [ENTRIES-1:0]        cfg_o,
    output logic [ENTRIES-1:0][WORD_W-1:0]  addr_o
);

    typedef struct packed {
        entry_cfg_t [ENTRIES-1:0]        cfg;
        logic [ENTRIES-1:0][WORD_W-1:0]  addr;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && !bank_q.cfg[wr_idx].lock) begin
            if (wr_is_addr) begin
                bank_d.addr[wr_idx] = wr_data;
            end else begin
                bank_d.cfg[wr_idx]       = entry_cfg_t'(wr_data[7:0]);
                bank_d.cfg[wr_idx].spare = 2'b00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign cfg_o  = bank_q.cfg;
    assign addr_o = bank_q.addr;

endmodule

// File: rtl/mg_match.sv
module mg_match
    import mg_pkg::*;
#(
    parameter int unsigned WORD_W = 30
) (
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] lo_bound,
    input  logic [WORD_W-1:0] own,
    input  region_mode_e      mode,
    output logic              hit
);

    logic [WORD_W-1:0] care_mask;
    logic              range_hit;
    logic              align_hit;

    always_comb begin
        // trailing ones plus the first zero above them are "don't care"
        care_mask = ~(own ^ (own + WORD_W'(1)));
        align_hit = ((word ^ own) & care_mask) == '0;
        range_hit = (word >= lo_bound) && (word < own);
        unique case (mode)
            MODE_RANGE: hit = range_hit;
            MODE_ALIGN: hit = align_hit;
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/mg_pick.sv
module mg_pick
    import mg_pkg::*;
#(
    parameter int unsigned ENTRIES = 16
) (
    input  logic [ENTRIES-1:0]        hit_vec,
    input  entry_cfg_t [ENTRIES-1:0]  cfg,
    input  logic [1:0]                req_kind,
    input  logic                      req_mach,
    output logic [ENTRIES-1:0]        win_vec,
    output logic                      any_hit,
    output logic                      win_locked,
    output logic                      allow
);

    entry_cfg_t sel;
    logic       permit;
    logic       unused_spare;

    always_comb begin
        win_vec = hit_vec & (~hit_vec + ENTRIES'(1));
        any_hit = |hit_vec;
        sel     = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (win_vec[i]) sel = cfg[i];
        end
        win_locked = sel.lock;
        unique case (access_kind_e'(req_kind))
            KIND_LOAD:  permit = sel.pr;
            KIND_STORE: permit = sel.pw;
            KIND_FETCH: permit = sel.px;
            default:    permit = 1'b0;
        endcase
        if (!any_hit)            allow = req_mach;
        else if (req_mach && !sel.lock) allow = 1'b1;
        else                     allow = permit;
    end

    assign unused_spare = ^{sel.spare, sel.mode};

endmodule

// File: rtl/mem_guard.sv
module mem_guard
    import mg_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned ADDR_W  = 32,
    localparam int unsigned WORD_W = ADDR_W - 2,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_is_addr,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_kind,
    input  logic               req_mach,
    output logic               allow
);

    entry_cfg_t [ENTRIES-1:0]        cfg_q;
    logic [ENTRIES-1:0][WORD_W-1:0]  addr_q;
    logic [ENTRIES-1:0]              hit_vec;
    logic [ENTRIES-1:0]              win_vec;
    logic                            any_hit;
    logic                            win_locked;
    logic [WORD_W-1:0]               word;
    logic                            unused_lsb;

    assign word       = req_addr[ADDR_W-1:2];
    assign unused_lsb = ^req_addr[1:0];

    mg_regs #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_is_addr (wr_is_addr),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .cfg_o      (cfg_q),
        .addr_o     (addr_q)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [WORD_W-1:0] lo;
        if (g == 0) begin : g_first
            assign lo = '0;
        end else begin : g_rest
            assign lo = addr_q[g-1];
        end
        mg_match #(.WORD_W(WORD_W)) u_match (
            .word     (word),
            .lo_bound (lo),
            .own      (addr_q[g]),
            .mode     (cfg_q[g].mode),
            .hit      (hit_vec[g])
        );
    end

    mg_pick #(.ENTRIES(ENTRIES)) u_pick (
        .hit_vec    (hit_vec),
        .cfg        (cfg_q),
        .req_kind   (req_kind),
        .req_mach   (req_mach),
        .win_vec    (win_vec),
        .any_hit    (any_hit),
        .win_locked (win_locked),
        .allow      (allow)
    );

endmodule

// File: rtl/mg_checker.sv
module mg_checker #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned WORD_W  = 30,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_is_addr,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [WORD_W-1:0]               wr_data,
    input  logic [1:0]                      req_kind,
    input  logic                            req_mach,
    input  logic                            allow,
    input  logic [ENTRIES-1:0][7:0]         cfg_q,
    input  logic [ENTRIES-1:0][WORD_W-1:0]  addr_q,
    input  logic [ENTRIES-1:0]              win_vec,
    input  logic                            any_hit,
    input  logic                            win_locked
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_lock
        AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[g][7] |=> ($stable(cfg_q[g]) && $stable(addr_q[g]))); // R10
    end

    AST_CFG_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_is_addr && !cfg_q[wr_idx][7])
        |=> (cfg_q[$past(wr_idx)] == ($past(wr_data[7:0]) & 8'h9F))); // R11

    AST_ADDR_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_is_addr && !cfg_q[wr_idx][7])
        |=> (addr_q[$past(wr_idx)] == $past(wr_data))); // R11

    AST_LOWER_NOMATCH_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_mach && !any_hit) |-> !allow); // R8

    AST_MACH_DEFAULT_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mach && !(any_hit && win_locked)) |-> allow); // R9

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_vec) && ((|win_vec) == any_hit)); // R6

    AST_RESERVED_KIND_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == 2'd3 && (!req_mach || (any_hit && win_locked))) |-> !allow); // R7

endmodule

bind mem_guard mg_checker #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_is_addr (wr_is_addr),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .req_kind   (req_kind),
    .req_mach   (req_mach),
    .allow      (allow),
    .cfg_q      (cfg_q),
    .addr_q     (addr_q),
    .win_vec    (win_vec),
    .any_hit    (any_hit),
    .win_locked (win_locked)
);

// File: tb/tb_mem_guard.sv
`timescale 1ns/1ps
module tb_mem_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_is_addr = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [29:0] wr_data = '0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_mach = 1'b0;
    logic        allow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit    exp;
        string tag;
    } item_t;

    item_t q[$];

    always #5 clk = ~clk;

    mem_guard dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_addr(wr_is_addr),
        .wr_idx(wr_idx), .wr_data(wr_data), .req_addr(req_addr),
        .req_kind(req_kind), .req_mach(req_mach), .allow(allow)
    );

    task automatic wr(input bit is_addr, input int idx, input logic [29:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_is_addr = is_addr; wr_idx = 4'(idx); wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input logic [1:0] k, input bit m,
                         input bit exp, input string tag);
        item_t it;
        @(negedge clk);
        req_addr = a; req_kind = k; req_mach = m;
        it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compares the combinational answer shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (allow !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%b expected=%b", it.tag, allow, it.exp);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        probe(32'h100, 2'd0, 1'b0, 1'b0, "R1 user load after reset");
        probe(32'h100, 2'd1, 1'b1, 1'b1, "R1 machine store after reset");
        // entry 0: range below 0x1000, read only (cfg 0x09, R2)
        wr(1, 0, 30'h400);
        wr(0, 0, 30'h09);
        probe(32'h0000, 2'd0, 1'b0, 1'b1, "R4 entry0 lowest address");
        probe(32'h0FFC, 2'd0, 1'b0, 1'b1, "R4 entry0 top word load");
        probe(32'h0FFC, 2'd1, 1'b0, 1'b0, "R7 entry0 store denied");
        probe(32'h1000, 2'd0, 1'b0, 1'b0, "R8 above entry0 no match");
        // entry 1: range 0x1000..0x1FFF, read/write (0x0B)
        wr(1, 1, 30'h800);
        wr(0, 1, 30'h0B);
        probe(32'h1000, 2'd1, 1'b0, 1'b1, "R4 entry1 lower bound inclusive");
        probe(32'h1FFC, 2'd1, 1'b0, 1'b1, "R4 entry1 last word");
        probe(32'h2000, 2'd1, 1'b0, 1'b0, "R4 entry1 upper bound exclusive");
        probe(32'h1800, 2'd2, 1'b0, 1'b0, "R7 entry1 fetch denied");
        // entry 2: aligned 256 bytes at 0x8000, fetch only (0x1C)
        wr(1, 2, 30'h201F);
        wr(0, 2, 30'h1C);
        probe(32'h80FC, 2'd2, 1'b0, 1'b1, "R5 aligned 256B last word");
        probe(32'h8000, 2'd2, 1'b0, 1'b1, "R5 aligned 256B base");
        probe(32'h8100, 2'd2, 1'b0, 1'b0, "R5 aligned 256B past end");
        probe(32'h7FFC, 2'd2, 1'b0, 1'b0, "R5 aligned 256B below base");
        probe(32'h8010, 2'd0, 1'b0, 1'b0, "R7 fetch-only region load denied");
        // entry 3: aligned 8 bytes at 0x9000, read only (0x19)
        wr(1, 3, 30'h2400);
        wr(0, 3, 30'h19);
        probe(32'h9004, 2'd0, 1'b0, 1'b1, "R5 minimum region second word");
        probe(32'h9008, 2'd0, 1'b0, 1'b0, "R5 minimum region past end");
        probe(32'h8FFC, 2'd0, 1'b0, 1'b0, "R5 minimum region below base");
        // entry 4: aligned 64 KiB at 0, all permits (0x1F)
        wr(1, 4, 30'h1FFF);
        wr(0, 4, 30'h1F);
        probe(32'h0FFC, 2'd1, 1'b0, 1'b0, "R6 entry0 wins over entry4");
        probe(32'h3000, 2'd1, 1'b0, 1'b1, "R6 entry4 covers gap");
        probe(32'h8100, 2'd2, 1'b0, 1'b1, "R6 entry4 behind entry2");
        probe(32'h3000, 2'd3, 1'b0, 1'b0, "R7 reserved kind user denied");
        probe(32'h3000, 2'd3, 1'b1, 1'b1, "R9 machine reserved kind unlocked entry");
        // entry 5: mode 2 with all permits, address all ones (0x17)
        wr(1, 5, 30'h3FFFFFFF);
        wr(0, 5, 30'h17);
        probe(32'h20000, 2'd0, 1'b0, 1'b0, "R3 mode2 matches nothing");
        // entry 5 off with mode 0 but permits set
        wr(0, 5, 30'h07);
        probe(32'h20000, 2'd0, 1'b0, 1'b0, "R3 mode0 matches nothing");
        probe(32'h0FFC, 2'd1, 1'b1, 1'b1, "R9 machine store unlocked read-only");
        // entry 6: aligned 4 KiB at 0x40000, read only, locked (0x99)
        wr(1, 6, 30'h101FF);
        wr(0, 6, 30'h99);
        probe(32'h40010, 2'd1, 1'b1, 1'b0, "R9 machine store locked read-only");
        probe(32'h40010, 2'd0, 1'b1, 1'b1, "R9 machine load locked read-only");
        probe(32'h40010, 2'd2, 1'b1, 1'b0, "R9 machine fetch locked");
        probe(32'h40010, 2'd3, 1'b1, 1'b0, "R7 machine reserved kind locked");
        // attempts to relax or move a locked entry
        wr(0, 6, 30'h1F);
        probe(32'h40010, 2'd1, 1'b1, 1'b0, "R10 locked cfg write ignored");
        wr(1, 6, 30'h2FFFF);
        probe(32'h40010, 2'd0, 1'b1, 1'b1, "R10 locked addr write ignored");
        probe(32'h80010, 2'd0, 1'b0, 1'b0, "R10 moved region absent");
        // write port: entry 7 address then config take effect (R11)
        wr(1, 7, 30'h30000);
        wr(0, 7, 30'h6B);
        probe(32'hA0000, 2'd1, 1'b0, 1'b1, "R11 entry7 range store");
        probe(32'hC0000, 2'd1, 1'b0, 1'b0, "R11 entry7 bound exclusive");
        // R12 same-cycle change of request
        probe(32'hA0000, 2'd2, 1'b0, 1'b0, "R12 fetch answer same cycle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule